// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single memory-mapped control and status word that records why the system last came out of reset and lets software ask for a new one. Five bits at the top of the word carry meaning: three are status flags that software clears by writing ones, and two are request flags that software sets by writing ones. A soft power-on request re-arms the block so that the next system reset is reported as a power-on. A soft warm request asks for a reset without re-arming. Two board buttons, one for power-on style resets and one for warm resets, mark their own status flags and also request a reset.

The block tells a first reset apart from later ones with a two-state machine. In `ARM_FIRST` the next system reset is treated as power-on. Transition `T_LOAD` leaves `ARM_FIRST` for `ARM_LATER` when the system reset input is seen. Transition `T_REARM` returns from `ARM_LATER` to `ARM_FIRST` on a soft power-on write. A second machine drives the request output. It goes from `PULSE_IDLE` to `PULSE_FIRE` on `T_TRIGGER` (a request write or a button edge) and returns on `T_DONE`, or when the system reset input is high. The only output of this machine is the one-cycle request.

Top module: `rst_status_ctrl`

## Requirements
- R1: While `por_n` is low, the word reads 0, `rst_req` is low and the block is armed for a first reset.
- R2: The first cycle with `sys_rst` high after power-up, or after a re-arm, loads the word with 0x8000_0000 (bit 31 only).
- R3: Further cycles with `sys_rst` high while not armed leave the word unchanged.
- R4: A write to the active word clears each of bits 31, 28 and 27 whose data bit is 1 and leaves the rest alone. Bits 26:0 always read 0.
- R5: A write with bit 30 set sets bit 30, requests a reset and re-arms, so that the next `sys_rst` loads 0x8000_0000.
- R6: A write with bit 29 set and bit 30 clear sets bit 29 and requests a reset without re-arming.
- R7: Writing 0 to bits 30 or 29 does not clear them. Only the power-on load of R2 or `por_n` clears them.
- R8: `rst_req` is high for exactly one cycle: the cycle after the clock edge that samples the triggering write or button edge.
- R9: A rising edge on `btn_pwr` sets bit 28, and one on `btn_warm` sets bit 27. Each edge requests a reset. A level that stays high gives no further request.
- R10: The active word is the upper word of the 8-byte window at `WIN_BASE` (`reg_addr` bit 2 = 1). The lower word and addresses outside the window read 0, and writes to them do nothing.
- R11: While `sys_rst` is high, register writes and button edges change nothing and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| sys_rst | input | 1 | System reset in progress, synchronous, active high |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data, combinational from the address |
| btn_pwr | input | 1 | Power-on style reset button, synchronous |
| btn_warm | input | 1 | Warm reset button, synchronous |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the buttons, `sys_rst` and the write port are already synchronous to `clk` and are sampled at the rising edge. They also assume that `sys_rst` is the only thing that can override a write in the same cycle. The bench changes every input on the falling edge and reads the outputs on the falling edge, so each input is stable for a whole cycle around the edge that samples it. It sweeps all 32 values of the five meaningful bits, starting from a state where both button flags are set. It follows each write with a system reset and predicts the word, the arming and the request pulse with its own arithmetic model.

// File: rtl/rscr_pkg.sv
package rscr_pkg;
    localparam int DATA_W    = 32;
    localparam int FIELD_LSB = 27;
    localparam int FIELD_W   = DATA_W - FIELD_LSB;

    // bit positions inside the stored five-bit field (word bit - FIELD_LSB)
    localparam int F_PWR_ON    = 31 - FIELD_LSB;
    localparam int F_SOFT_PWR  = 30 - FIELD_LSB;
    localparam int F_SOFT_WARM = 29 - FIELD_LSB;
    localparam int F_BTN_PWR   = 28 - FIELD_LSB;
    localparam int F_BTN_WARM  = 27 - FIELD_LSB;

    localparam logic [FIELD_W-1:0] W1C_MASK  = 5'b10011;
    localparam logic [FIELD_W-1:0] W1S_MASK  = 5'b01100;
    localparam logic [FIELD_W-1:0] LOAD_VAL  = 5'b10000;

    typedef enum logic {ARM_FIRST, ARM_LATER} arm_state_t;
    typedef enum logic {PULSE_IDLE, PULSE_FIRE} pulse_state_t;
endpackage

// File: rtl/rscr_edge_detect.sv
module rscr_edge_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl_i[g];
        end
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/rscr_arm_fsm.sv
module rscr_arm_fsm
    import rscr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic rearm_i,
    output logic first_o
);
    arm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ARM_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_FIRST: if (sys_rst) state_d = ARM_LATER;   // T_LOAD
            ARM_LATER: if (rearm_i) state_d = ARM_FIRST;   // T_REARM
            default:   state_d = ARM_FIRST;
        endcase
    end

    always_comb first_o = (state_q == ARM_FIRST);

    // R5: a re-arm request in a later state lands in ARM_FIRST
    p_rearm_lands_r5: assert property (@(posedge clk) disable iff (!por_n)
        (rearm_i && !sys_rst) |=> first_o);
endmodule

// File: rtl/rscr_pulse_fsm.sv
module rscr_pulse_fsm
    import rscr_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic hold_i,
    input  logic trig_i,
    output logic req_o
);
    pulse_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = PULSE_IDLE;
        unique case (state_q)
            PULSE_IDLE: if (trig_i && !hold_i) state_d = PULSE_FIRE;  // T_TRIGGER
            PULSE_FIRE: if (trig_i && !hold_i) state_d = PULSE_FIRE;  // next trigger
            default:    state_d = PULSE_IDLE;                          // T_DONE
        endcase
    end

    always_comb req_o = (state_q == PULSE_FIRE);

    p_pulse_follows_r8: assert property (@(posedge clk) disable iff (!por_n)
        (trig_i && !hold_i) |=> req_o);
    p_pulse_has_cause_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!(trig_i && !hold_i)) |=> !req_o);
endmodule

// File: rtl/rscr_status_reg.sv
module rscr_status_reg
    import rscr_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               hold_i,
    input  logic               load_i,
    input  logic               wr_i,
    input  logic [FIELD_W-1:0] wfield_i,
    input  logic               set_bpwr_i,
    input  logic               set_bwarm_i,
    output logic [FIELD_W-1:0] field_o
);
    logic [FIELD_W-1:0] field_q, field_d;

    always_comb begin
        field_d = field_q;
        if (load_i) begin
            field_d = LOAD_VAL;
        end else if (!hold_i) begin
            if (wr_i) begin
                field_d = field_d & ~(wfield_i & W1C_MASK);
                field_d = field_d | (wfield_i & W1S_MASK);
            end
            if (set_bpwr_i)  field_d[F_BTN_PWR]  = 1'b1;
            if (set_bwarm_i) field_d[F_BTN_WARM] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) field_q <= '0;
        else        field_q <= field_d;
    end

    assign field_o = field_q;

    // R7: set-only bits survive everything except the power-on load
    p_soft_pwr_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        (field_o[F_SOFT_PWR] && !load_i) |=> field_o[F_SOFT_PWR]);
    p_soft_warm_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        (field_o[F_SOFT_WARM] && !load_i) |=> field_o[F_SOFT_WARM]);
    // R11: hold without load freezes the field
    p_hold_freezes_r11: assert property (@(posedge clk) disable iff (!por_n)
        (hold_i && !load_i) |=> $stable(field_o));
endmodule

// File: rtl/rst_status_ctrl.sv
module rst_status_ctrl
    import rscr_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              btn_pwr,
    input  logic              btn_warm,
    output logic              rst_req
);
    localparam int BTN_N = 2;

    logic               win_hit, upper_hit, wr_upper;
    logic [FIELD_W-1:0] wfield, field;
    logic [BTN_N-1:0]   btn_rise;
    logic               arm_first, load_por, soft_pwr_wr, trig;
    logic               unused_bits;

    assign unused_bits = ^{reg_wdata[FIELD_LSB-1:0], reg_addr[1:0], WIN_BASE[2:0]};

    assign win_hit   = (reg_addr[ADDR_W-1:3] == WIN_BASE[ADDR_W-1:3]);
    assign upper_hit = win_hit && reg_addr[2];
    assign wr_upper  = reg_we && upper_hit;
    assign wfield    = reg_wdata[DATA_W-1:FIELD_LSB];

    rscr_edge_detect #(.N(BTN_N)) u_edges (
        .clk    (clk),
        .por_n  (por_n),
        .lvl_i  ({btn_warm, btn_pwr}),
        .rise_o (btn_rise)
    );

    assign soft_pwr_wr = wr_upper && wfield[F_SOFT_PWR] && !sys_rst;

    rscr_arm_fsm u_arm (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .rearm_i (soft_pwr_wr),
        .first_o (arm_first)
    );

    assign load_por = sys_rst && arm_first;

    rscr_status_reg u_stat (
        .clk         (clk),
        .por_n       (por_n),
        .hold_i      (sys_rst),
        .load_i      (load_por),
        .wr_i        (wr_upper),
        .wfield_i    (wfield),
        .set_bpwr_i  (btn_rise[0]),
        .set_bwarm_i (btn_rise[1]),
        .field_o     (field)
    );

    assign trig = (wr_upper && (wfield[F_SOFT_PWR] || wfield[F_SOFT_WARM]))
               || (|btn_rise);

    rscr_pulse_fsm u_pulse (
        .clk    (clk),
        .por_n  (por_n),
        .hold_i (sys_rst),
        .trig_i (trig),
        .req_o  (rst_req)
    );

    always_comb begin
        reg_rdata = '0;
        if (upper_hit) reg_rdata[DATA_W-1:FIELD_LSB] = field;
    end

    p_first_loads_r2: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && arm_first) |=> (reg_rdata == 32'h8000_0000 || !upper_hit));
    p_later_keeps_r3: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && !arm_first) |=> $stable(field));
    p_btn_sets_r9: assert property (@(posedge clk) disable iff (!por_n)
        (btn_rise[0] && !sys_rst) |=> field[F_BTN_PWR]);
    p_warm_no_rearm_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!arm_first && !soft_pwr_wr) |=> !arm_first);
    p_no_req_in_reset_r11: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> !rst_req);
endmodule

// File: tb/tb_rst_status_ctrl.sv
module tb_rst_status_ctrl;
    localparam logic [15:0] A_UP  = 16'hF024;
    localparam logic [15:0] A_LOW = 16'hF020;
    localparam logic [15:0] A_OUT = 16'hF02C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst = 1'b0, reg_we = 1'b0;
    logic        btn_pwr = 1'b0, btn_warm = 1'b0;
    logic [15:0] reg_addr = A_UP;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        rst_req;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] m_reg;
    bit          m_armed;

    always #5 clk = ~clk;

    rst_status_ctrl dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
        reg_addr = A_UP;
    endtask

    // write at a falling edge; return pulse level in the next two cycles
    task automatic wr(logic [15:0] a, logic [31:0] d, output logic p1, output logic p2);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_UP;
        p1 = rst_req;
        @(negedge clk);
        p2 = rst_req;
    endtask

    task automatic press(bit warm, output logic p1, output logic p2);
        @(negedge clk);
        if (warm) btn_warm = 1'b1; else btn_pwr = 1'b1;
        @(negedge clk);
        p1 = rst_req;
        btn_warm = 1'b0; btn_pwr = 1'b0;
        @(negedge clk);
        p2 = rst_req;
    endtask

    task automatic do_sysrst();
        @(negedge clk);
        sys_rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 no request during sys_rst", {31'b0, rst_req}, 32'h0);
        sys_rst = 1'b0;
        if (m_armed) m_reg = 32'h8000_0000;
        m_armed = 1'b0;
    endtask

    function automatic void m_write(logic [4:0] v);
        logic [31:0] val;
        val = {v, 27'b0};
        m_reg = m_reg & ~(val & 32'h9800_0000);
        m_reg = m_reg | (val & 32'h6000_0000);
        if (v[3]) m_armed = 1'b1;
    endfunction

    initial begin : watchdog
        #1_500_000ns;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic p1, p2;
        m_reg = '0; m_armed = 1'b1;
        #22;
        rd_chk("R1 word in power-up reset", A_UP, 32'h0);
        chk("R1 no request in power-up reset", {31'b0, rst_req}, 32'h0);
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 word after power-up", A_UP, 32'h0);

        do_sysrst();
        rd_chk("R2 first reset loads bit 31", A_UP, 32'h8000_0000);

        press(1'b0, p1, p2);
        m_reg |= 32'h1000_0000;
        chk("R9 pwr button pulse", {31'b0, p1}, 32'h1);
        chk("R8 pulse one cycle", {31'b0, p2}, 32'h0);
        rd_chk("R9 pwr button bit 28", A_UP, m_reg);
        do_sysrst();
        rd_chk("R3 later reset keeps word", A_UP, m_reg);

        // held button: one pulse only
        @(negedge clk); btn_warm = 1'b1;
        @(negedge clk); p1 = rst_req;
        @(negedge clk); p2 = rst_req;
        @(negedge clk);
        chk("R9 held warm button first pulse", {31'b0, p1}, 32'h1);
        chk("R9 held warm button no repeat", {31'b0, p2 | rst_req}, 32'h0);
        btn_warm = 1'b0;
        m_reg |= 32'h0800_0000;
        rd_chk("R9 warm button bit 27", A_UP, m_reg);

        for (int v = 0; v < 32; v++) begin
            logic [4:0] f;
            f = v[4:0];
            press(1'b0, p1, p2); m_reg |= 32'h1000_0000;
            press(1'b1, p1, p2); m_reg |= 32'h0800_0000;
            wr(A_UP, {f, 27'h5A5_A5A5}, p1, p2);
            m_write(f);
            chk($sformatf("R8 R5 R6 pulse after write %0d", v), {31'b0, p1},
                {31'b0, (f[3] | f[2])});
            chk($sformatf("R8 single cycle %0d", v), {31'b0, p2}, 32'h0);
            rd_chk($sformatf("R4 R7 word after write %0d", v), A_UP, m_reg);
            do_sysrst();
            rd_chk($sformatf("R2 R5 R6 word after reset %0d", v), A_UP, m_reg);
        end

        // stray addresses
        wr(A_LOW, 32'hFFFF_FFFF, p1, p2);
        chk("R10 lower word write no pulse", {31'b0, p1}, 32'h0);
        rd_chk("R10 lower word reads zero", A_LOW, 32'h0);
        rd_chk("R10 lower write ignored", A_UP, m_reg);
        wr(A_OUT, 32'hFFFF_FFFF, p1, p2);
        chk("R10 outside write no pulse", {31'b0, p1}, 32'h0);
        rd_chk("R10 outside reads zero", A_OUT, 32'h0);
        rd_chk("R10 outside write ignored", A_UP, m_reg);

        // clear the status flags, then try to change things during sys_rst
        wr(A_UP, 32'h9800_0000, p1, p2);
        m_write(5'b10011);
        rd_chk("R4 status cleared", A_UP, m_reg);
        @(negedge clk);
        sys_rst = 1'b1; reg_we = 1'b1; reg_wdata = 32'hF800_0000; btn_pwr = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; btn_pwr = 1'b0;
        chk("R11 no pulse from write in sys_rst", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        sys_rst = 1'b0;
        if (m_armed) begin m_reg = 32'h8000_0000; m_armed = 1'b0; end
        @(negedge clk);
        chk("R11 no pulse after sys_rst", {31'b0, rst_req}, 32'h0);
        rd_chk("R11 word unchanged by blocked input", A_UP, m_reg);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule